// File: doc/BRIEF.md
# Buffered Wide Tick Counter

This block is a free-running counter, 64 bits wide by default, that software reaches through a small word-addressed register bus. Because the bus is only 32 bits wide, the count is split into a low word and a high word. A read of the low word also copies the high word, as it stands in that same cycle, into a snapshot register. Software reads the low word first and then the snapshot, and the two words together form one consistent count, even if the low word wraps in between.

The counter advances by one on each cycle in which the channel is enabled and the `tick_i` input is high. A 64-bit compare register and a count-mode bit set what happens when the counter reaches the compare value. In one mode the counter returns to zero. In the other mode it keeps running. Either way, a sticky match flag records the event, and software clears the flag by writing 1 to it. The channel is started by writing to a set-only enable register. Software may write either counter word at any time, for example to clear the count before starting it.

The parameter `WIDE=0` builds a 32-bit variant. In that variant the whole count is read and written at the high-word address.

Top module: `osb_timer`

## Requirements
- R1: After reset every register reads 0: the counter, the snapshot, the compare register, the control register and the enable register. The counter does not advance on `tick_i` until the channel has been enabled.
- R2: While the channel is enabled, the counter adds exactly 1 on each cycle with `tick_i` high, and the carry from the low word into the high word takes effect in that same cycle. With `tick_i` low the count holds.
- R3: A write to the enable register (address 6) that has bit 15 set enables the channel. A write without bit 15 has no effect. Only reset disables the channel again. Reading address 6 returns the enable state in bit 15.
- R4: A read returns its data on `rdata_o` in the cycle after the request. A read of the low word (address 0) returns the low count and copies the high count of that same cycle into the snapshot register (address 2). The high word (address 1) returns the live high count.
- R5: Each low-word read overwrites the snapshot. If a second low-word read falls between another reader's low read and snapshot read, and the low word has wrapped in the meantime, the value that reader assembles is exactly 2^32 too high.
- R6: Bit 15 of the control register (address 5) is the count mode. When it is 0, a counting cycle in which the count equals the compare value (address 3 low, address 4 high) loads 0. When it is 1, that cycle adds 1 as usual.
- R7: Bit 0 of the control register is the match flag. It is set by a counting cycle in which the count equals the compare value. A control write with bit 0 at 1 clears it, and a control write with bit 0 at 0 leaves it unchanged.
- R8: A write to address 0 or address 1 loads that counter word on the next edge and leaves the other word alone. The counter does not advance in that cycle, even if `tick_i` is high.
- R9: With `WIDE=0` the counter is 32 bits and is read and written at address 1. It wraps from 2^32-1 to 0. Addresses 0, 2 and 4 read 0, and the compare value is taken from address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable for this cycle |
| req_i | input | 1 | Bus request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle after a read request |

## Verification
A wrong internal state shows up at the ports quickly. A counter that misses a carry or skips a tick is off in the very next low-word or high-word read. A snapshot captured in the wrong cycle makes the assembled value differ from the expected arithmetic by a whole high-word step, and this shows as soon as the snapshot is read after a wrap. A wrong compare mode or a wrong flag shows in the counter value or in the control readback one tick after the match. The bench sweeps start values just below the low-word wrap against several tick counts, so carry faults are exposed wherever they occur.

// File: rtl/osb_pkg.sv
package osb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_CNT_LO  = 3'd0,
    REG_CNT_HI  = 3'd1,
    REG_HI_SNAP = 3'd2,
    REG_CMP_LO  = 3'd3,
    REG_CMP_HI  = 3'd4,
    REG_CTRL    = 3'd5,
    REG_EN_SET  = 3'd6
  } reg_addr_e;

  localparam int unsigned MODE_BIT = 15;
  localparam int unsigned EN_BIT   = 15;
  localparam int unsigned FLAG_BIT = 0;
endpackage

// File: rtl/osb_count.sv
module osb_count
  import osb_pkg::*;
#(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned NW    = CNT_W / WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              free_i,
  input  logic [CNT_W-1:0]  cmp_i,
  input  logic [NW-1:0]     wr_word_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              hit_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wr_any;

  assign wr_any = |wr_word_i;
  assign hit_o  = run_i && (cnt_q == cmp_i);
  assign cnt_o  = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_any) begin
      // software load wins over counting
      for (int w = 0; w < int'(NW); w++)
        if (wr_word_i[w]) cnt_d[w*WORD_W +: WORD_W] = wdata_i;
    end else if (run_i) begin
      cnt_d = (hit_o && !free_i) ? '0 : cnt_q + ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  a_r2_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wr_any && !(hit_o && !free_i)) |=> cnt_o == $past(cnt_o) + ONE);
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_any) |=> $stable(cnt_o));
  a_r6_zero_on_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && hit_o && !free_i && !wr_any) |=> cnt_o == '0);
  a_r8_no_step_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_word_i[0]) |=> cnt_o[WORD_W-1:0] == $past(wdata_i));
endmodule

// File: rtl/osb_regs.sv
module osb_regs
  import osb_pkg::*;
#(
  parameter bit          WIDE  = 1'b1,
  parameter int unsigned CNT_W = WIDE ? 64 : 32,
  parameter int unsigned NW    = CNT_W / WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              hit_i,
  output logic [NW-1:0]     wr_word_o,
  output logic              free_o,
  output logic              en_o,
  output logic [CNT_W-1:0]  cmp_o
);
  logic wr, rd;
  logic en_q, free_q, flag_q;
  logic [CNT_W-1:0]  cmp_q;
  logic [WORD_W-1:0] rdata_q, rd_mux;
  logic [WORD_W-1:0] lo_rd, hi_rd, snap_rd, cmph_rd, ctrl_rd, en_rd;

  assign wr = req_i && we_i;
  assign rd = req_i && !we_i;

  function automatic logic [ADDR_W-1:0] cmp_addr(int w);
    return (w == 0) ? REG_CMP_LO : REG_CMP_HI;
  endfunction

  if (WIDE) begin : g_wide
    logic [WORD_W-1:0] snap_q;
    assign wr_word_o = {wr && addr_i == REG_CNT_HI, wr && addr_i == REG_CNT_LO};
    assign lo_rd     = cnt_i[WORD_W-1:0];
    assign hi_rd     = cnt_i[CNT_W-1 -: WORD_W];
    assign cmph_rd   = cmp_q[CNT_W-1 -: WORD_W];
    assign snap_rd   = snap_q;

    // low-word read freezes the high word of the same cycle
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                          snap_q <= '0;
      else if (rd && addr_i == REG_CNT_LO)  snap_q <= cnt_i[CNT_W-1 -: WORD_W];

    a_r4_snap_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd && addr_i == REG_CNT_LO) |=> snap_q == $past(cnt_i[CNT_W-1 -: WORD_W]));
    a_r5_snap_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rd && addr_i == REG_CNT_LO) |=> $stable(snap_q));
    a_r4_lo_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd && addr_i == REG_CNT_LO) |=> rdata_o == $past(cnt_i[WORD_W-1:0]));
  end else begin : g_narrow
    assign wr_word_o = wr && addr_i == REG_CNT_HI;
    assign lo_rd     = '0;
    assign hi_rd     = cnt_i;
    assign cmph_rd   = '0;
    assign snap_rd   = '0;
  end

  always_comb begin
    ctrl_rd           = '0;
    ctrl_rd[MODE_BIT] = free_q;
    ctrl_rd[FLAG_BIT] = flag_q;
    en_rd             = '0;
    en_rd[EN_BIT]     = en_q;
  end

  always_comb begin
    case (addr_i)
      REG_CNT_LO:  rd_mux = lo_rd;
      REG_CNT_HI:  rd_mux = hi_rd;
      REG_HI_SNAP: rd_mux = snap_rd;
      REG_CMP_LO:  rd_mux = cmp_q[WORD_W-1:0];
      REG_CMP_HI:  rd_mux = cmph_rd;
      REG_CTRL:    rd_mux = ctrl_rd;
      REG_EN_SET:  rd_mux = en_rd;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      free_q  <= 1'b0;
      flag_q  <= 1'b0;
      cmp_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (rd) rdata_q <= rd_mux;
      if (wr && addr_i == REG_EN_SET && wdata_i[EN_BIT]) en_q <= 1'b1;
      if (wr && addr_i == REG_CTRL) free_q <= wdata_i[MODE_BIT];
      // a match in the same cycle beats the clear
      if (hit_i)                                                flag_q <= 1'b1;
      else if (wr && addr_i == REG_CTRL && wdata_i[FLAG_BIT])   flag_q <= 1'b0;
      for (int w = 0; w < int'(NW); w++)
        if (wr && addr_i == cmp_addr(w)) cmp_q[w*WORD_W +: WORD_W] <= wdata_i;
    end
  end

  assign rdata_o = rdata_q;
  assign free_o  = free_q;
  assign en_o    = en_q;
  assign cmp_o   = cmp_q;

  a_r3_enable_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> en_q);
  a_r3_zero_write_no_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !(wr && addr_i == REG_EN_SET && wdata_i[EN_BIT])) |=> !en_q);
  a_r7_flag_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> flag_q);
  a_r7_flag_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && wr && addr_i == REG_CTRL && wdata_i[FLAG_BIT]) |=> !flag_q);
endmodule

// File: rtl/osb_timer.sv
module osb_timer
  import osb_pkg::*;
#(
  parameter bit WIDE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o
);
  localparam int unsigned CNT_W = WIDE ? 64 : 32;
  localparam int unsigned NW    = CNT_W / WORD_W;

  logic [CNT_W-1:0] cnt, cmp;
  logic [NW-1:0]    wr_word;
  logic             hit, free, en, run;

  assign run = en && tick_i;

  osb_regs #(.WIDE(WIDE), .CNT_W(CNT_W), .NW(NW)) u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i, .rdata_o,
    .cnt_i(cnt), .hit_i(hit), .wr_word_o(wr_word),
    .free_o(free), .en_o(en), .cmp_o(cmp)
  );

  osb_count #(.CNT_W(CNT_W), .NW(NW)) u_count (
    .clk_i, .rst_ni, .run_i(run), .free_i(free), .cmp_i(cmp),
    .wr_word_i(wr_word), .wdata_i, .cnt_o(cnt), .hit_o(hit)
  );

  a_r2_disabled_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !(|wr_word)) |=> $stable(cnt));
endmodule

// File: tb/sim_osb_timer.sv
module sim_osb_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [31:0] r0, r1;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  osb_timer #(.WIDE(1'b1)) u0 (.clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata0));
  osb_timer #(.WIDE(1'b0)) u1 (.clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .req_i(req),
    .we_i(we), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata1));

  task automatic chk(string req_s, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req_s, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a);
    @(negedge clk); req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk); req = 1'b0;
    r0 = rdata0; r1 = rdata1;
  endtask

  task automatic ticks(int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic set_cnt(logic [31:0] hi, logic [31:0] lo);
    wr(3'd0, lo);
    wr(3'd1, hi);
  endtask

  initial begin
    logic [31:0] a_lo, a_hi, b_lo;
    logic [63:0] start;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(3'(a));
      chk("R1 reset wide", {32'd0, r0}, 64'd0);
      chk("R1 reset narrow", {32'd0, r1}, 64'd0);
    end
    ticks(5);
    rd(3'd0); chk("R1 no count before enable", {32'd0, r0}, 64'd0);

    // R3 enable set register
    wr(3'd5, 32'h0000_8000);
    wr(3'd6, 32'h0000_7FFF);
    rd(3'd6); chk("R3 zero bit15 ignored", {32'd0, r0}, 64'd0);
    ticks(3);
    rd(3'd0); chk("R3 still stopped", {32'd0, r0}, 64'd0);
    wr(3'd6, 32'h0000_8000);
    rd(3'd6); chk("R3 enabled", {32'd0, r0}, 64'h8000);

    // R2 counting and hold
    ticks(5);
    rd(3'd0); chk("R2 five ticks", {32'd0, r0}, 64'd5);
    repeat (3) @(negedge clk);
    rd(3'd0); chk("R2 hold without tick", {32'd0, r0}, 64'd5);

    // R2 sweep around the low-word carry
    for (int k = 0; k < 6; k++) begin
      for (int n = 1; n < 4; n++) begin
        start = {32'(k * 3 + n), 32'hFFFF_FFFF - 32'(k)};
        set_cnt(start[63:32], start[31:0]);
        ticks(n);
        rd(3'd0); a_lo = r0;
        rd(3'd2); a_hi = r0;
        chk("R2 carry sweep", {a_hi, a_lo}, start + 64'(n));
      end
    end

    // R8 write while ticking: no advance in the write cycle
    set_cnt(32'h0000_0009, 32'h0000_0000);
    @(negedge clk); tick = 1'b1; req = 1'b1; we = 1'b1; addr = 3'd0; wdata = 32'h1234_0000;
    @(negedge clk); req = 1'b0; we = 1'b0; tick = 1'b0;
    rd(3'd0); chk("R8 low write exact", {32'd0, r0}, 64'h1234_0000);
    rd(3'd1); chk("R8 high untouched", {32'd0, r0}, 64'd9);

    // R4 snapshot of the high word at the low read
    set_cnt(32'h3, 32'hFFFF_FFFD);
    rd(3'd0); chk("R4 low read", {32'd0, r0}, 64'hFFFF_FFFD);
    ticks(4);
    rd(3'd2); chk("R4 snapshot keeps old high", {32'd0, r0}, 64'd3);
    rd(3'd1); chk("R4 live high", {32'd0, r0}, 64'd4);

    // R5 interleaved readers tear by 2^32
    set_cnt(32'h7, 32'hFFFF_FFFE);
    rd(3'd0); a_lo = r0;
    ticks(3);
    rd(3'd0); b_lo = r0;
    rd(3'd2); a_hi = r0;
    chk("R5 torn value", {a_hi, a_lo} - 64'h7_FFFF_FFFE, 64'h1_0000_0000);
    chk("R5 second reader consistent", {a_hi, b_lo}, 64'h8_0000_0001);

    // R6 and R7: reset-on-compare, flag
    wr(3'd5, 32'h0000_0001);
    rd(3'd5); chk("R7 flag cleared by write 1", {32'd0, r0}, 64'd0);
    wr(3'd3, 32'd10);
    wr(3'd4, 32'd0);
    rd(3'd3); chk("R6 compare readback", {32'd0, r0}, 64'd10);
    set_cnt(32'd0, 32'd7);
    ticks(3);
    rd(3'd0); chk("R6 reaches compare", {32'd0, r0}, 64'd10);
    rd(3'd5); chk("R7 no flag before match tick", {32'd0, r0}, 64'd0);
    ticks(1);
    rd(3'd0); chk("R6 zero after match", {32'd0, r0}, 64'd0);
    rd(3'd5); chk("R7 flag set", {32'd0, r0}, 64'd1);
    wr(3'd5, 32'h0000_0000);
    rd(3'd5); chk("R7 write 0 keeps flag", {32'd0, r0}, 64'd1);
    wr(3'd5, 32'h0000_0001);
    rd(3'd5); chk("R7 write 1 clears flag", {32'd0, r0}, 64'd0);

    // R6 free-running mode passes compare
    wr(3'd5, 32'h0000_8000);
    set_cnt(32'd0, 32'd7);
    ticks(5);
    rd(3'd0); chk("R6 free mode continues", {32'd0, r0}, 64'd12);
    rd(3'd5); chk("R7 flag in free mode", {32'd0, r0}, 64'h8001);

    // R6 compare on the high word
    wr(3'd5, 32'h0000_0001);
    wr(3'd3, 32'd2);
    wr(3'd4, 32'd1);
    rd(3'd4); chk("R6 compare high readback", {32'd0, r0}, 64'd1);
    set_cnt(32'd1, 32'd0);
    ticks(3);
    rd(3'd0); a_lo = r0;
    rd(3'd2); a_hi = r0;
    chk("R6 64-bit match clears", {a_hi, a_lo}, 64'd0);

    // R9 narrow variant
    wr(3'd5, 32'h0000_8000);
    wr(3'd1, 32'hFFFF_FFFD);
    ticks(5);
    rd(3'd1); chk("R9 narrow wraps at 2^32", {32'd0, r1}, 64'd2);
    rd(3'd0); chk("R9 narrow low reads 0", {32'd0, r1}, 64'd0);
    rd(3'd2); chk("R9 narrow snapshot reads 0", {32'd0, r1}, 64'd0);
    rd(3'd4); chk("R9 narrow compare high reads 0", {32'd0, r1}, 64'd0);
    rd(3'd3); chk("R9 narrow compare low", {32'd0, r1}, 64'd2);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule